// File: doc/BRIEF.md
# Deterministic Token Passing Arbiter

This block hands out exclusive access tokens to a set of processor ports so that the order of token ownership depends only on the sequence of port events, never on arrival timing. Each process context owns its own token. Each token circulates among the ports currently assigned to that context, in ascending port index with wraparound. A holder keeps the token for its whole quantum. It gives the token up when it reports a quantum end, when it starts spinning on a lock, or, in ordered-commit mode, after it has committed one speculative quantum.

For every port the arbiter reports whether that port holds its context's token. It also reports whether every other port of the same context is waiting for the token, which a holder needs before it performs a sharing-state change. Ports without an active thread are stepped over in one cycle, so a context never stalls on an idle port.

Top module: `dtok_arbiter`

## Requirements
- R1: After reset the token of every context sits at port index 0. If port 0 does not belong to a context, that context's token moves to its lowest-index member port on the first clock edge.
- R2: Within one context the token visits member ports in ascending index order and wraps from the highest member back to the lowest.
- R3: The holder keeps the token while it raises no quantum end, lock spin or granted commit. When `quantum_end` of the holder is high at a rising edge, the next member holds the token from that edge on, which makes a one-cycle handoff.
- R4: A port's `tok_held` is high only when it is the current holder of the token of the context it is assigned to. At most one port of a context shows `tok_held` high in any cycle.
- R5: `others_blocked[p]` is high exactly when port p holds its token and every other active port of the same context has `tok_wait` high. A holder that is the sole member of its context sees it high.
- R6: With `ord_commit_en` high, `commit_grant[p]` equals `commit_req[p]` of the holder, in the same cycle. A granted commit passes the token at that edge, and the pass is a single step even if a quantum end arrives at the same time. Requests from non-holders, and all requests while `ord_commit_en` is low, give no grant.
- R7: A holder that raises `spin_start` passes the token at that edge, without waiting for its quantum to end.
- R8: Contexts are independent. Port p belongs to context `port_ctx[p*CTX_W +: CTX_W]`. Two ports of different contexts may hold tokens in the same cycle, and an event in one context never moves another context's token.
- R9: A port whose `port_active` bit is low is never a member and is skipped. If the holder stops being a member, the token moves to the next member at the next edge. A lone member that ends its quantum keeps the token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ord_commit_en | input | 1 | Ordered-commit mode enable |
| port_active | input | NUM_PORTS | Port has an active thread |
| port_ctx | input | NUM_PORTS*CTX_W | Context assignment per port |
| quantum_end | input | NUM_PORTS | Quantum boundary reached |
| spin_start | input | NUM_PORTS | Port started spinning on a lock |
| tok_wait | input | NUM_PORTS | Port is blocked waiting for its token |
| commit_req | input | NUM_PORTS | Request to commit a speculative quantum |
| tok_held | output | NUM_PORTS | Port holds its context's token |
| others_blocked | output | NUM_PORTS | Holder sees all other context members waiting |
| commit_grant | output | NUM_PORTS | Ordered commit granted this cycle |

## Verification
On every cycle the embedded properties check the following: at most one holder exists per context, a holder with no pass event keeps the token, any pass or skip moves the token when another member exists, commit grants go only to holders and only in ordered mode, and the all-blocked flag is raised only for a holder. The exact visiting order, including wraparound and the step over idle ports, can be shown only by the bench's scenarios. The same holds for the reset position, the vacuous all-blocked case for a lone member, and the isolation between contexts when ports are reassigned.

// File: rtl/dtok_pkg.sv
package dtok_pkg;
   typedef enum logic [1:0] {
      PASS_NONE   = 2'd0,
      PASS_QEND   = 2'd1,
      PASS_SPIN   = 2'd2,
      PASS_COMMIT = 2'd3
   } pass_cause_e;
endpackage

// File: rtl/dtok_next_sel.sv
module dtok_next_sel #(
   parameter int NUM_PORTS = 4,
   localparam int IW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic [NUM_PORTS-1:0] member,
   input  logic [IW-1:0]        cur,
   output logic [IW-1:0]        nxt,
   output logic                 found
);
   // first member strictly after cur, ascending, wrapping (may return cur itself)
   always_comb begin
      nxt   = cur;
      found = 1'b0;
      for (int i = 1; i <= NUM_PORTS; i++) begin
         int unsigned idx;
         idx = (int'(cur) + i) % NUM_PORTS;
         if (!found && member[idx]) begin
            found = 1'b1;
            nxt   = IW'(idx);
         end
      end
   end
endmodule

// File: rtl/dtok_ctx_ring.sv
module dtok_ctx_ring
   import dtok_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   localparam int IW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ord_en,
   input  logic [NUM_PORTS-1:0] member,
   input  logic [NUM_PORTS-1:0] q_end,
   input  logic [NUM_PORTS-1:0] spin,
   input  logic [NUM_PORTS-1:0] creq,
   output logic [NUM_PORTS-1:0] held,
   output logic [NUM_PORTS-1:0] grant
);
   localparam logic [NUM_PORTS-1:0] ONE = {{(NUM_PORTS-1){1'b0}}, 1'b1};

   logic [IW-1:0] holder_q, nxt_idx;
   logic          nxt_found, is_mem, advance;
   pass_cause_e   cause;

   dtok_next_sel #(.NUM_PORTS(NUM_PORTS)) u_next (
      .member (member),
      .cur    (holder_q),
      .nxt    (nxt_idx),
      .found  (nxt_found)
   );

   assign is_mem = member[holder_q];

   always_comb begin
      cause = PASS_NONE;
      if (is_mem) begin
         if (ord_en && creq[holder_q])  cause = PASS_COMMIT;
         else if (spin[holder_q])       cause = PASS_SPIN;
         else if (q_end[holder_q])      cause = PASS_QEND;
      end
   end

   assign held    = is_mem ? (ONE << holder_q) : '0;
   assign grant   = (cause == PASS_COMMIT) ? (ONE << holder_q) : '0;
   assign advance = (cause != PASS_NONE) || (!is_mem && nxt_found);

   always_ff @(posedge clk) begin
      if (!rst_n)       holder_q <= '0;
      else if (advance) holder_q <= nxt_idx;
   end

   // R3: no pass event keeps the holder in place
   p_keep_token_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mem && cause == PASS_NONE) |=> $stable(holder_q));
   // R2: a pass with another member present moves the token
   p_pass_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cause != PASS_NONE && $countones(member) > 1) |=> (holder_q != $past(holder_q)));
   // R9: a non-member holder is stepped over
   p_skip_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_mem && nxt_found) |=> (holder_q != $past(holder_q)));
   // R6: one commit per hold
   p_one_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((|grant) && $countones(member) > 1) |=> ((grant & $past(grant)) == '0));
endmodule

// File: rtl/dtok_blk_agg.sv
module dtok_blk_agg #(
   parameter int NUM_PORTS = 4,
   parameter int CTX_W     = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_PORTS-1:0]       active,
   input  logic [NUM_PORTS*CTX_W-1:0] ctx,
   input  logic [NUM_PORTS-1:0]       waiting,
   input  logic [NUM_PORTS-1:0]       held,
   output logic [NUM_PORTS-1:0]       all_blk
);
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic [NUM_PORTS-1:0] ok;
      for (genvar q = 0; q < NUM_PORTS; q++) begin : g_peer
         if (q == p) begin : g_self
            assign ok[q] = 1'b1;
         end else begin : g_other
            assign ok[q] = waiting[q] || !active[q] ||
                           (ctx[q*CTX_W +: CTX_W] != ctx[p*CTX_W +: CTX_W]);
         end
      end
      assign all_blk[p] = held[p] && (&ok);
   end

   // R5: the flag only ever reaches a holder
   p_flag_holder_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((all_blk & ~held) == '0));
endmodule

// File: rtl/dtok_arbiter.sv
module dtok_arbiter #(
   parameter int NUM_PORTS = 4,
   parameter int NUM_CTX   = 2,
   localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ord_commit_en,
   input  logic [NUM_PORTS-1:0]       port_active,
   input  logic [NUM_PORTS*CTX_W-1:0] port_ctx,
   input  logic [NUM_PORTS-1:0]       quantum_end,
   input  logic [NUM_PORTS-1:0]       spin_start,
   input  logic [NUM_PORTS-1:0]       tok_wait,
   input  logic [NUM_PORTS-1:0]       commit_req,
   output logic [NUM_PORTS-1:0]       tok_held,
   output logic [NUM_PORTS-1:0]       others_blocked,
   output logic [NUM_PORTS-1:0]       commit_grant
);
   if (NUM_PORTS < 2) begin : g_bad_ports
      $error("dtok_arbiter: NUM_PORTS must be at least 2");
   end
   if (NUM_CTX < 1 || NUM_CTX > NUM_PORTS) begin : g_bad_ctx
      $error("dtok_arbiter: NUM_CTX must lie in 1..NUM_PORTS");
   end

   logic [NUM_PORTS-1:0] member [NUM_CTX];
   logic [NUM_PORTS-1:0] held_c [NUM_CTX];
   logic [NUM_PORTS-1:0] grant_c[NUM_CTX];

   for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_mem
         assign member[c][p] = port_active[p] &&
                               (port_ctx[p*CTX_W +: CTX_W] == CTX_W'(c));
      end

      dtok_ctx_ring #(.NUM_PORTS(NUM_PORTS)) u_ring (
         .clk    (clk),
         .rst_n  (rst_n),
         .ord_en (ord_commit_en),
         .member (member[c]),
         .q_end  (quantum_end),
         .spin   (spin_start),
         .creq   (commit_req),
         .held   (held_c[c]),
         .grant  (grant_c[c])
      );

      // R4: one holder per context at most
      p_single_holder_r4: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(tok_held & member[c]));
   end

   always_comb begin
      tok_held     = '0;
      commit_grant = '0;
      for (int c = 0; c < NUM_CTX; c++) begin
         tok_held     = tok_held | held_c[c];
         commit_grant = commit_grant | grant_c[c];
      end
   end

   dtok_blk_agg #(.NUM_PORTS(NUM_PORTS), .CTX_W(CTX_W)) u_agg (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (port_active),
      .ctx     (port_ctx),
      .waiting (tok_wait),
      .held    (tok_held),
      .all_blk (others_blocked)
   );

   // R6: grants only to holders
   p_grant_holder_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((commit_grant & ~tok_held) == '0));
   // R6: no grant outside ordered mode
   p_grant_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ord_commit_en |-> (commit_grant == '0));
endmodule

// File: tb/dtok_arbiter_tb.sv
module dtok_arbiter_tb_top;
   localparam int NP = 4;
   localparam int NV = 22;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ord;
   logic [NP-1:0] act, ctx, qend, spin, blk, creq;
   logic [NP-1:0] held, aob, grant;
   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   dtok_arbiter #(.NUM_PORTS(NP), .NUM_CTX(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .ord_commit_en(ord),
      .port_active(act), .port_ctx(ctx), .quantum_end(qend),
      .spin_start(spin), .tok_wait(blk), .commit_req(creq),
      .tok_held(held), .others_blocked(aob), .commit_grant(grant)
   );

   // {req, act, ctx, qend, spin, blk, creq, ord, held, aob, grant}
   localparam logic [40:0] VECS [NV] = '{
      {4'd1, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0001, 4'b0000, 4'b0000}, // R1
      {4'd3, 4'b1111, 4'b0000, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0001, 4'b0000, 4'b0000}, // R3
      {4'd3, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0010, 4'b0000, 4'b0000}, // R3
      {4'd3, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0010, 4'b0000, 4'b0000}, // R3
      {4'd7, 4'b1111, 4'b0000, 4'b0000, 4'b0010, 4'b0000, 4'b0000, 1'b0, 4'b0010, 4'b0000, 4'b0000}, // R7
      {4'd5, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b1011, 4'b0000, 1'b0, 4'b0100, 4'b0100, 4'b0000}, // R5
      {4'd5, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0011, 4'b0000, 1'b0, 4'b0100, 4'b0000, 4'b0000}, // R5
      {4'd2, 4'b1111, 4'b0000, 4'b0100, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0100, 4'b0000, 4'b0000}, // R2
      {4'd2, 4'b1111, 4'b0000, 4'b1000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b1000, 4'b0000, 4'b0000}, // R2
      {4'd6, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0010, 1'b1, 4'b0001, 4'b0000, 4'b0000}, // R6
      {4'd6, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 1'b0, 4'b0001, 4'b0000, 4'b0000}, // R6
      {4'd6, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 1'b1, 4'b0001, 4'b0000, 4'b0001}, // R6
      {4'd6, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0010, 4'b0000, 4'b0000}, // R6
      {4'd9, 4'b1111, 4'b1010, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b0000}, // R9
      {4'd8, 4'b1111, 4'b1010, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0110, 4'b0000, 4'b0000}, // R8
      {4'd8, 4'b1111, 4'b1010, 4'b0000, 4'b0000, 4'b0001, 4'b0000, 1'b0, 4'b1100, 4'b0100, 4'b0000}, // R8
      {4'd5, 4'b1111, 4'b1010, 4'b0000, 4'b0000, 4'b0010, 4'b0000, 1'b0, 4'b1100, 4'b1000, 4'b0000}, // R5
      {4'd9, 4'b0101, 4'b0000, 4'b0100, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0100, 4'b0000, 4'b0000}, // R9
      {4'd9, 4'b0001, 4'b0000, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0001, 4'b0001, 4'b0000}, // R9
      {4'd9, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0001, 4'b0001, 4'b0000}, // R9
      {4'd8, 4'b0001, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b0000}, // R8
      {4'd8, 4'b0001, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0001, 4'b0001, 4'b0000}  // R8
   };

   task automatic check(input string req, input string what,
                        input logic [NP-1:0] actual, input logic [NP-1:0] exp);
      checks++;
      if (actual !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, actual, exp);
      end
   endtask

   task automatic drive(input logic [NP-1:0] a, input logic [NP-1:0] cx,
                        input logic [NP-1:0] qe, input logic [NP-1:0] sp,
                        input logic [NP-1:0] bk, input logic [NP-1:0] cr,
                        input logic o);
      act = a; ctx = cx; qend = qe; spin = sp; blk = bk; creq = cr; ord = o;
   endtask

   initial begin
      #400000;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      drive(4'b1111, 4'b0000, '0, '0, '0, '0, 1'b0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // table walk: drive at falling edge, sample 1 ns later
      for (int v = 0; v < NV; v++) begin
         logic [40:0] e;
         string rq;
         int n0, n1;
         e = VECS[v];
         drive(e[36:33], e[32:29], e[28:25], e[24:21], e[20:17], e[16:13], e[12]);
         #1;
         rq = $sformatf("R%0d", e[40:37]);
         check(rq, $sformatf("vec%0d tok_held", v), held, e[11:8]);
         check(rq, $sformatf("vec%0d others_blocked", v), aob, e[7:4]);
         check(rq, $sformatf("vec%0d commit_grant", v), grant, e[3:0]);
         // R4: per-context holder count from the outputs
         n0 = 0; n1 = 0;
         for (int p = 0; p < NP; p++) begin
            if (held[p] && !ctx[p]) n0++;
            if (held[p] &&  ctx[p]) n1++;
         end
         check("R4", $sformatf("vec%0d holders>1", v),
               {2'b00, (n0 > 1), (n1 > 1)}, 4'b0000);
         @(negedge clk);
      end

      // R1: reset mid-run, all ports in context 1, token back at port 0
      drive(4'b1111, 4'b1111, '0, '0, '0, '0, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1", "ctx1 start", held, 4'b0001);

      // R1: port 0 not in context 0, that token goes to port 2 after one edge
      @(negedge clk);
      rst_n = 1'b0;
      drive(4'b1111, 4'b0011, '0, '0, '0, '0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1", "first cycle after reset", held, 4'b0001);
      @(negedge clk);
      #1;
      check("R1", "ctx0 first member", held, 4'b0101);

      // R6: commit and quantum end together give a single step
      @(negedge clk);
      rst_n = 1'b0;
      drive(4'b1111, 4'b0000, '0, '0, '0, '0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      drive(4'b1111, 4'b0000, 4'b0001, '0, '0, 4'b0001, 1'b1);
      #1;
      check("R6", "grant with qend", grant, 4'b0001);
      @(negedge clk);
      drive(4'b1111, 4'b0000, '0, '0, '0, '0, 1'b0);
      #1;
      check("R6", "single step", held, 4'b0010);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule